// File: doc/BRIEF.md
# Selectable Radar Video Pulse Stretcher

This block widens short, already-thresholded radar echo pulses so that a single-range-cell hit stays visible on a display. A one-bit, positive-going video input is first brought into the system clock domain. It is then fed into an eight-stage delay line, which yields eight copies of the input, each one shift later than the last. The output is the OR of the live synchronized input with one of three groups of leading taps: the first two, the first five, or all eight.

A 3-bit range code picks the tap group. A transmit pulse-width flag picks the shift rate. With short pulses the delay line steps on every clock. With long pulses it steps once every four clocks, using a divide-by-four clock enable. Any given tap group therefore stretches an echo four times further in time when long pulses are in use. The block runs from one clock and is meant to sit between the video comparator and the range-cell buffer.

Top module: `vps_stretch_top`

## Requirements
- R1: While `rst_ni` is low, `video_o` is 0, the delay line is empty and the rate counter is zero. After reset is released, `video_o` stays 0 as long as `video_i` stays 0.
- R2: `video_i` passes through a two-flop synchronizer and a registered output. A rising input sampled at clock edge n can first appear on `video_o` after edge n+2.
- R3: Range codes 0 and 1 select taps Q1..Q2, codes 2 to 4 select Q1..Q5, and codes 5 to 7 select Q1..Q8. In short-pulse mode (`long_pulse_i`=0), a one-clock input pulse gives a `video_o` pulse of exactly 3, 6 or 9 clocks, in that order.
- R4: In short-pulse mode the delay line shifts on every clock.
- R5: In long-pulse mode (`long_pulse_i`=1) the delay line shifts once every four clocks. An input pulse held for four clocks with N taps selected gives an output pulse of 4N+1 to 4N+4 clocks, which is 33 to 36 clocks for the eight-tap group.
- R6: A change of `long_pulse_i` restarts the rate counter at zero. The delay-line contents are kept, so a stretch already in progress continues at the new rate.
- R7: The output is the OR of the synchronized input and the selected taps. Two one-clock pulses spaced closer than the stretch length merge into one output pulse. Pulses spaced further apart give separate output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| video_i | input | 1 | Thresholded positive-going video bit |
| long_pulse_i | input | 1 | 1 selects the long transmit pulse (shift every fourth clock) |
| range_i | input | 3 | Range code selecting the tap group |
| video_o | output | 1 | Stretched video bit |

## Verification
Single one-clock pulses are sent with every range code in short-pulse mode. The resulting widths of 3, 6 and 9 clocks show both the code-to-group mapping and the one-clock shift rate. Four-clock pulses in long-pulse mode show the divide-by-four rate through the 4N+1 to 4N+4 width window. A pulse whose mode is switched mid-stretch shows whether the delay-line contents survive the change. Closely and widely spaced pulse pairs show the OR merge, and an idle input shows that nothing is produced from no echo.

// File: rtl/vps_pkg.sv
package vps_pkg;
  localparam int unsigned STAGES = 8;
  localparam int unsigned TAPS_SHORT = 2;
  localparam int unsigned TAPS_MID = 5;

  typedef enum logic [1:0] {GRP_SHORT, GRP_MID, GRP_FULL} tap_grp_e;

  function automatic tap_grp_e grp_of(input logic [2:0] code);
    if (code <= 3'd1) return GRP_SHORT;
    else if (code <= 3'd4) return GRP_MID;
    else return GRP_FULL;
  endfunction

  function automatic logic [STAGES-1:0] low_mask(input int unsigned n);
    logic [STAGES-1:0] m;
    for (int i = 0; i < STAGES; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/vps_sync.sv
module vps_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[DEPTH-2:0], d_i};
  end

  assign q_o = ff_q[DEPTH-1];
endmodule

// File: rtl/vps_rate_en.sv
module vps_rate_en #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_i,
  output logic en_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      long_q <= long_i;
      if (long_i != long_q || cnt_q == LAST) cnt_q <= '0;
      else                                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o = !long_q || (cnt_q == LAST);

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_i != long_q) |=> (cnt_q == '0)); // R6
  AST_LONG_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && long_q && $past(long_q) && long_i) |=> !en_o); // R5
  AST_SHORT_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!long_q) |-> en_o); // R4
endmodule

// File: rtl/vps_delay_line.sv
module vps_delay_line #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              d_i,
  output logic [STAGES-1:0] tap_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign tap_o = sr_q;

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sr_q)); // R6
  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (sr_q[0] == $past(d_i))); // R4
endmodule

// File: rtl/vps_stretch_top.sv
module vps_stretch_top
  import vps_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       video_i,
  input  logic       long_pulse_i,
  input  logic [2:0] range_i,
  output logic       video_o
);
  logic              vid_s;
  logic              shift_en;
  logic [STAGES-1:0] taps;
  logic [STAGES-1:0] sel_mask;
  logic              out_q;

  vps_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(video_i), .q_o(vid_s)
  );

  vps_rate_en #(.DIV(DIV)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .long_i(long_pulse_i), .en_o(shift_en)
  );

  vps_delay_line #(.STAGES(STAGES)) u_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(shift_en), .d_i(vid_s), .tap_o(taps)
  );

  always_comb begin
    unique case (grp_of(range_i))
      GRP_SHORT: sel_mask = low_mask(TAPS_SHORT);
      GRP_MID:   sel_mask = low_mask(TAPS_MID);
      default:   sel_mask = low_mask(STAGES);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= vid_s | (|(taps & sel_mask));
  end

  assign video_o = out_q;

  AST_LIVE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_s |=> video_o); // R7
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vid_s && taps == '0) |=> !video_o); // R1
  AST_Q1_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taps[0] |=> video_o); // R3
endmodule

// File: tb/vps_stretch_top_tb.sv
module vps_stretch_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid = 1'b0;
  logic lng = 1'b0;
  logic [2:0] rng = 3'd0;
  logic out;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vps_stretch_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .video_i(vid), .long_pulse_i(lng),
    .range_i(rng), .video_o(out)
  );

  task automatic chk(input string req, input int act, input int exp_lo, input int exp_hi);
    n_run++;
    if (act < exp_lo || act > exp_hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive a pulse of len clocks, then count high output cycles over win clocks
  task automatic pulse_width(input int len, input int win, output int highs);
    highs = 0;
    for (int i = 0; i < len + win; i++) begin
      @(negedge clk);
      if (out) highs++;
      vid = (i < len);
    end
    vid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(3);
    chk("R1 reset out", int'(out), 0, 0);
    rst_n = 1'b1;
    begin
      int h = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (out) h++; end
      chk("R1 idle out", h, 0, 0);
    end
  endtask

  task automatic t_latency;
    int first = -1;
    lng = 1'b0; rng = 3'd0; idle(12);
    @(negedge clk); vid = 1'b1;
    @(negedge clk); vid = 1'b0;
    // input sampled at edge 0; out must rise after edge 2
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (out && first < 0) first = i;
    end
    chk("R2 latency", first, 2, 2);
  endtask

  task automatic t_short_codes;
    int h;
    int exp_w;
    lng = 1'b0;
    for (int c = 0; c < 8; c++) begin
      rng = 3'(c);
      idle(16);
      pulse_width(1, 24, h);
      exp_w = (c <= 1) ? 3 : (c <= 4) ? 6 : 9;
      chk($sformatf("R3 R4 code %0d width", c), h, exp_w, exp_w);
    end
  endtask

  task automatic t_long;
    int h;
    lng = 1'b1;
    idle(8);
    rng = 3'd0; idle(40); pulse_width(4, 60, h); chk("R5 long 2-tap", h, 9, 12);
    rng = 3'd3; idle(40); pulse_width(4, 60, h); chk("R5 long 5-tap", h, 21, 24);
    rng = 3'd7; idle(40); pulse_width(4, 80, h); chk("R5 long 8-tap", h, 33, 36);
    lng = 1'b0; idle(40);
  endtask

  task automatic t_switch;
    int h = 0;
    lng = 1'b0; rng = 3'd7; idle(16);
    @(negedge clk); vid = 1'b1;
    @(negedge clk); vid = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (out) h++;
      if (i == 3) lng = 1'b1;
    end
    // kept contents: remaining stages drain at quarter rate, well beyond 9
    chk("R6 stretch kept over mode switch", h, 20, 40);
    lng = 1'b0; idle(20);
  endtask

  task automatic t_merge;
    int h;
    int rises;
    logic prev;
    lng = 1'b0; rng = 3'd0; idle(16);
    // two pulses 2 clocks apart with 3-clock stretch: one merged pulse of 5
    h = 0; rises = 0; prev = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out) h++;
      if (out && !prev) rises++;
      prev = out;
      vid = (i == 0 || i == 2);
    end
    vid = 1'b0;
    chk("R7 merged highs", h, 5, 5);
    chk("R7 merged count", rises, 1, 1);
    idle(10);
    h = 0; rises = 0; prev = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (out) h++;
      if (out && !prev) rises++;
      prev = out;
      vid = (i == 0 || i == 6);
    end
    vid = 1'b0;
    chk("R7 separate highs", h, 6, 6);
    chk("R7 separate count", rises, 2, 2);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_short_codes();
        t_long();
        t_switch();
        t_merge();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule